// File: doc/BRIEF.md
# Transceiver Interrupt Status Register with Deferred Request

This block is the 8-bit interrupt status register of a contactless transceiver front end. It gathers one-cycle event pulses from the transmit engine, the receive engine, the FIFO level monitor and the decoder error detectors into sticky flags. It drives a single interrupt request line to the host. A transmit or receive phase sets its flag as soon as the phase begins, but the request line only rises once that phase has ended. While a phase is running, the flags that belong to other sources are frozen.

The host reaches the block over a simple strobe bus with separate read and write strobes. A read of the status address returns the flags in the same cycle and clears them, together with the request line, at the clock edge that ends the read. A write to the protocol control address also clears the flags and the line. That write stores the control byte, whose top bit disables receive CRC error reporting. A mode input picks between reader meanings and card-emulation meanings for the five low flags. Driving the enable input low holds the whole block at zero.

Top module: `xcvr_irq_status`

## Requirements
- R1: In reader mode the flag bits mean: 7 transmit, 6 receive start, 5 FIFO level, 4 CRC error, 3 parity error, 2 framing/EOF error, 1 collision, 0 no-response timeout. Inputs `err_evt[4:0]` map one to one onto flag bits 4..0.
- R2: The flags, the request line, the stored control byte and the phase trackers are 0 after `rst_n` low and while `enable` is low. A write to address 0x01 zeroes the flags and the request line one cycle later.
- R3: A read strobe at address 0x0C presents the current flags on `bus_rdata` in the same cycle. The flags and `irq` are zero in the next cycle unless an event arrives in that read cycle.
- R4: A `tx_start` pulse sets bit 7 in the next cycle, and `irq` stays low while the transmit phase runs. A `tx_end` pulse during the phase makes `irq` high in the next cycle.
- R5: An `rx_sof` pulse sets bit 6 in the next cycle, and `irq` stays low while the receive phase runs. An `rx_end` pulse during the phase makes `irq` high in the next cycle.
- R6: From the `tx_start` cycle through the `tx_end` cycle, `err_evt` is ignored. `fifo_evt` still sets bit 5 but does not raise `irq`.
- R7: From the `rx_sof` cycle through the `rx_end` cycle, both `fifo_evt` and `err_evt` are ignored.
- R8: In reader mode, `err_evt[4]` sets bit 4 only when bit 7 of the stored control byte (the no-CRC bit) is 0. When the event is dropped it does not raise `irq`.
- R9: In card-emulation mode (`mode_card`=1) the bits 4..0 mean protocol error, anticollision completed, RF level change, collision avoidance done, and collision avoidance failed. In this mode bit 4 is never gated by the no-CRC bit.
- R10: A `fifo_evt` or accepted `err_evt` outside any phase sets its flag and makes `irq` high in the next cycle.
- R11: When an event arrives in the same cycle as a clearing read or control write, its flag is set and its `irq` effect is kept in the next cycle. All older flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| enable | input | 1 | Block enable; low holds everything at zero |
| mode_card | input | 1 | 0 reader meanings, 1 card-emulation meanings |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Status flags at 0x0C, control byte at 0x01, else 0 |
| tx_start | input | 1 | Transmission begins (pulse) |
| tx_end | input | 1 | Transmission finished (pulse) |
| rx_sof | input | 1 | Start of frame received (pulse) |
| rx_end | input | 1 | Reception finished (pulse) |
| fifo_evt | input | 1 | FIFO level threshold crossed (pulse) |
| err_evt | input | 5 | Error or status events for flag bits 4..0 (pulses) |
| irq | output | 1 | Interrupt request to the host |

## Verification
Two functions can land in the same cycle: a clearing access (a status read or a control write) and a new FIFO or error event. The bench provokes this by raising the read strobe or the control write in the very cycle it pulses `fifo_evt` or `err_evt`, after older flags have been left pending. It judges the outcome in three ways. `bus_rdata` in the read cycle must show only the older flags. The next read must show only the new event's bit. `irq` must be high in between.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
  localparam int STAT_W   = 8;
  localparam int ERR_W    = 5;
  localparam int BIT_TX   = 7;
  localparam int BIT_RX   = 6;
  localparam int BIT_FIFO = 5;
  localparam int BIT_E4   = 4;

  typedef enum logic {MODE_READER = 1'b0, MODE_CARD = 1'b1} xirq_mode_e;

  // drop the CRC event in reader mode when CRC reporting is off
  function automatic logic [ERR_W-1:0] xirq_err_filter(input xirq_mode_e mode,
                                                        input logic nocrc,
                                                        input logic [ERR_W-1:0] ev);
    logic [ERR_W-1:0] r;
    r = ev;
    if (mode == MODE_READER && nocrc) r[BIT_E4] = 1'b0;
    return r;
  endfunction

  // event set mask wins over a same-cycle clear
  function automatic logic [STAT_W-1:0] xirq_next_flags(input logic [STAT_W-1:0] cur,
                                                         input logic clr,
                                                         input logic [STAT_W-1:0] set);
    return (clr ? '0 : cur) | set;
  endfunction

  function automatic logic xirq_next_irq(input logic cur, input logic clr, input logic raise);
    return raise | (cur & ~clr);
  endfunction
endpackage

// File: rtl/xirq_bus_decode.sv
`timescale 1ns/1ps
module xirq_bus_decode #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  STAT_ADDR = 8'h0C,
  parameter logic [7:0]  CTRL_ADDR = 8'h01
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              stat_rd,
  output logic              ctrl_rd,
  output logic              ctrl_wr,
  output logic              clr
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  assign stat_rd = bus_rd & (bus_addr == A_STAT);
  assign ctrl_rd = bus_rd & (bus_addr == A_CTRL);
  assign ctrl_wr = bus_wr & (bus_addr == A_CTRL);
  assign clr     = stat_rd | ctrl_wr;
endmodule

// File: rtl/xirq_phase_track.sv
`timescale 1ns/1ps
module xirq_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_i,
  input  logic stop_i,
  output logic active_o,
  output logic busy_o,
  output logic done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_o <= 1'b0;
    else if (!enable) active_o <= 1'b0;
    else              active_o <= (active_o & ~stop_i) | start_i;
  end

  // phase counts from its start pulse through its end pulse
  assign busy_o = active_o | start_i;
  assign done_o = active_o & stop_i;
endmodule

// File: rtl/xirq_event_gate.sv
`timescale 1ns/1ps
module xirq_event_gate
  import xirq_pkg::*;
(
  input  xirq_mode_e        mode_i,
  input  logic              nocrc_i,
  input  logic              tx_start_i,
  input  logic              rx_sof_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              fifo_evt_i,
  input  logic [ERR_W-1:0]  err_evt_i,
  output logic [STAT_W-1:0] set_o,
  output logic              raise_o
);
  logic              idle;
  logic [ERR_W-1:0]  err_ok;
  logic              fifo_ok;

  assign idle    = ~tx_busy_i & ~rx_busy_i;
  assign err_ok  = idle ? xirq_err_filter(mode_i, nocrc_i, err_evt_i) : '0;
  assign fifo_ok = fifo_evt_i & ~rx_busy_i;

  always_comb begin
    set_o           = '0;
    set_o[BIT_TX]   = tx_start_i;
    set_o[BIT_RX]   = rx_sof_i;
    set_o[BIT_FIFO] = fifo_ok;
    set_o[ERR_W-1:0] = err_ok;
  end

  assign raise_o = idle & (fifo_evt_i | (|err_ok));
endmodule

// File: rtl/xcvr_irq_status.sv
`timescale 1ns/1ps
module xcvr_irq_status
  import xirq_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] STAT_ADDR = 8'h0C,
  parameter logic [7:0] CTRL_ADDR = 8'h01,
  parameter int         NOCRC_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_card,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tx_start,
  input  logic              tx_end,
  input  logic              rx_sof,
  input  logic              rx_end,
  input  logic              fifo_evt,
  input  logic [4:0]        err_evt,
  output logic              irq
);
  logic              stat_rd, ctrl_rd, ctrl_wr, clr;
  logic              tx_active, tx_busy, tx_fin;
  logic              rx_active, rx_busy, rx_fin;
  logic [STAT_W-1:0] set_mask;
  logic              raise_now, raise_all;
  logic [STAT_W-1:0] flags_q;
  logic [7:0]        ctrl_q;
  logic              irq_q;
  xirq_mode_e        mode;

  assign mode = mode_card ? MODE_CARD : MODE_READER;

  xirq_bus_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_dec (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .stat_rd(stat_rd), .ctrl_rd(ctrl_rd), .ctrl_wr(ctrl_wr), .clr(clr));

  xirq_phase_track u_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_i(tx_start), .stop_i(tx_end),
    .active_o(tx_active), .busy_o(tx_busy), .done_o(tx_fin));

  xirq_phase_track u_rx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_i(rx_sof), .stop_i(rx_end),
    .active_o(rx_active), .busy_o(rx_busy), .done_o(rx_fin));

  xirq_event_gate u_gate (
    .mode_i(mode), .nocrc_i(ctrl_q[NOCRC_BIT]),
    .tx_start_i(tx_start), .rx_sof_i(rx_sof),
    .tx_busy_i(tx_busy), .rx_busy_i(rx_busy),
    .fifo_evt_i(fifo_evt), .err_evt_i(err_evt),
    .set_o(set_mask), .raise_o(raise_now));

  assign raise_all = raise_now | tx_fin | rx_fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
      ctrl_q  <= '0;
    end else if (!enable) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      flags_q <= xirq_next_flags(flags_q, clr, set_mask);
      irq_q   <= xirq_next_irq(irq_q, clr, raise_all);
      if (ctrl_wr) ctrl_q <= bus_wdata;
    end
  end

  assign irq = irq_q;

  always_comb begin
    if (stat_rd)      bus_rdata = flags_q;
    else if (ctrl_rd) bus_rdata = ctrl_q;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/xirq_status_chk.sv
`timescale 1ns/1ps
module xirq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       clr,
  input logic [7:0] flags_q,
  input logic       irq,
  input logic [7:0] set_mask,
  input logic       raise_all,
  input logic       tx_start,
  input logic       tx_active,
  input logic       tx_busy,
  input logic       tx_fin,
  input logic       rx_sof,
  input logic       rx_busy,
  input logic       rx_fin
);
  // R2: disabled block is zero one cycle later
  p_disable_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (flags_q == 8'h00) && !irq);

  // R3: clearing access with no new event empties the register
  p_clear_on_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr && set_mask == 8'h00 && !raise_all) |=> (flags_q == 8'h00) && !irq);

  // R4: transmit flag appears right after start
  p_tx_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_start) |=> flags_q[7]);

  // R4: request held back while transmit is active
  p_tx_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_active && !tx_fin && !irq && !raise_all) |=> !irq);

  // R4 R5: request raised once a phase ends
  p_phase_end_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (tx_fin || rx_fin)) |=> irq);

  // R5: receive flag appears right after start of frame
  p_rx_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_sof) |=> flags_q[6]);

  // R6: error flags frozen during transmit
  p_tx_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_busy && !clr) |=> flags_q[4:0] == $past(flags_q[4:0]));

  // R7: FIFO and error flags frozen during receive
  p_rx_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_busy && !clr) |=> flags_q[5:0] == $past(flags_q[5:0]));

  // R11: event in a clearing cycle keeps its request
  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr && raise_all) |=> irq);
endmodule

bind xcvr_irq_status xirq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .clr(clr), .flags_q(flags_q), .irq(irq),
  .set_mask(set_mask), .raise_all(raise_all), .tx_start(tx_start), .tx_active(tx_active),
  .tx_busy(tx_busy), .tx_fin(tx_fin), .rx_sof(rx_sof), .rx_busy(rx_busy), .rx_fin(rx_fin));

// File: tb/test_xcvr_irq_status.sv
`timescale 1ns/1ps
module test_xcvr_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       mode_card = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_start = 1'b0, tx_end = 1'b0, rx_sof = 1'b0, rx_end = 1'b0, fifo_evt = 1'b0;
  logic [4:0] err_evt = 5'h00;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xcvr_irq_status i_xcvr_irq_status (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_card(mode_card),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_start(tx_start), .tx_end(tx_end), .rx_sof(rx_sof),
    .rx_end(rx_end), .fifo_evt(fifo_evt), .err_evt(err_evt), .irq(irq));

  // behavioural reference model
  logic [7:0] m_flags = 8'h00;
  logic [7:0] m_ctrl  = 8'h00;
  bit m_irq = 0, m_tx = 0, m_rx = 0;

  always @(posedge clk) begin : model
    bit wipe, in_tx, in_rx, go;
    logic [7:0] add;
    if (!rst_n || !enable) begin
      m_flags = 8'h00; m_ctrl = 8'h00; m_irq = 0; m_tx = 0; m_rx = 0;
    end else begin
      wipe  = (bus_rd && bus_addr == 8'h0C) || (bus_wr && bus_addr == 8'h01);
      in_tx = m_tx || tx_start;
      in_rx = m_rx || rx_sof;
      add = 8'h00;
      if (tx_start) add = add | 8'h80;
      if (rx_sof)   add = add | 8'h40;
      if (fifo_evt && !in_rx) add = add | 8'h20;
      if (!in_tx && !in_rx) begin
        for (int k = 0; k < 5; k++) if (err_evt[k]) add[k] = 1'b1;
        if (!mode_card && m_ctrl[7]) add[4] = 1'b0;
      end
      go = (tx_end && m_tx) || (rx_end && m_rx) ||
           (!in_tx && !in_rx && (fifo_evt || add[4:0] != 5'h00));
      if (wipe) begin m_flags = 8'h00; m_irq = 0; end
      m_flags = m_flags | add;
      if (go) m_irq = 1;
      m_tx = tx_start || (m_tx && !tx_end);
      m_rx = rx_sof || (m_rx && !rx_end);
      if (bus_wr && bus_addr == 8'h01) m_ctrl = bus_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison of the request line against the model
  always @(negedge clk) if (rst_n && !done) check("R4/R10 irq cycle compare", irq, m_irq);

  task automatic idle();
    @(negedge clk);
    tx_start = 0; tx_end = 0; rx_sof = 0; rx_end = 0; fifo_evt = 0; err_evt = 5'h00;
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic rd_stat(input string req, input logic [7:0] exp);
    bus_rd = 1; bus_addr = 8'h0C;
    #1 check(req, bus_rdata, exp);
    check({req, " model"}, bus_rdata, m_flags);
    idle();
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    bus_wr = 1; bus_addr = 8'h01; bus_wdata = d;
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    check("R2 irq after reset", irq, 0);
    rd_stat("R2 flags after reset", 8'h00);

    // R10 idle FIFO event, R3 clear on read
    fifo_evt = 1; idle();
    check("R10 fifo irq immediate", irq, 1);
    rd_stat("R10 fifo flag", 8'h20);
    check("R3 irq dropped after read", irq, 0);
    rd_stat("R3 flags cleared", 8'h00);

    // R1 each reader error bit
    for (int k = 0; k < 5; k++) begin
      err_evt = 5'(1 << k); idle();
      check("R1 error irq", irq, 1);
      rd_stat("R1 error bit position", 8'(1 << k));
    end

    // R4 R6 transmit phase
    tx_start = 1; idle();
    check("R4 irq deferred at tx start", irq, 0);
    err_evt = 5'h1F; idle();
    fifo_evt = 1; idle();
    check("R6 fifo during tx no irq", irq, 0);
    tx_end = 1; err_evt = 5'h04; idle();
    check("R4 irq at tx end", irq, 1);
    rd_stat("R6 tx flags errors ignored", 8'hA0);

    // R5 R7 receive phase
    rx_sof = 1; idle();
    check("R5 irq deferred at rx start", irq, 0);
    fifo_evt = 1; err_evt = 5'h1F; idle();
    check("R7 no irq during rx", irq, 0);
    rx_end = 1; idle();
    check("R5 irq at rx end", irq, 1);
    rd_stat("R7 rx flags others ignored", 8'h40);

    // R8 no-CRC control bit
    wr_ctrl(8'h80);
    err_evt = 5'h10; idle();
    check("R8 dropped crc no irq", irq, 0);
    rd_stat("R8 crc suppressed", 8'h00);
    err_evt = 5'h08; idle();
    rd_stat("R8 parity still recorded", 8'h08);
    wr_ctrl(8'h00);
    err_evt = 5'h10; idle();
    rd_stat("R8 crc recorded", 8'h10);

    // R9 card mode ignores no-CRC bit
    wr_ctrl(8'h80);
    mode_card = 1;
    err_evt = 5'h10; idle();
    check("R9 protocol error irq", irq, 1);
    rd_stat("R9 protocol error flag", 8'h10);
    err_evt = 5'h1F; idle();
    rd_stat("R9 card bits", 8'h1F);
    mode_card = 0;
    wr_ctrl(8'h00);

    // R11 event in the same cycle as a clearing read
    err_evt = 5'h02; idle();
    fifo_evt = 1; bus_rd = 1; bus_addr = 8'h0C;
    #1 check("R11 read shows older flags", bus_rdata, 8'h02);
    idle();
    check("R11 irq kept", irq, 1);
    rd_stat("R11 only new flag", 8'h20);
    // R11 event in the same cycle as a control write
    fifo_evt = 1; idle();
    err_evt = 5'h01; bus_wr = 1; bus_addr = 8'h01; bus_wdata = 8'h00; idle();
    check("R11 irq kept on write", irq, 1);
    rd_stat("R11 write keeps new flag", 8'h01);

    // R2 control write clears
    fifo_evt = 1; err_evt = 5'h04; idle();
    wr_ctrl(8'h00);
    check("R2 irq cleared by ctrl write", irq, 0);
    rd_stat("R2 flags cleared by ctrl write", 8'h00);

    // R2 enable low clears
    fifo_evt = 1; idle();
    enable = 0; idle();
    check("R2 irq low while disabled", irq, 0);
    enable = 1;
    rd_stat("R2 flags cleared by disable", 8'h00);

    repeat (3) idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule